// File: doc/BRIEF.md
# Multiply-free decimating integrator-comb filter with DC-gain normaliser

This block lowers the sample rate of a stream of signed samples by an integer factor. It uses a cascade of integrators followed by a cascade of first-difference combs, so it needs only adders, subtractors and registers. Its transfer function is ((1 - z^-M)/(1 - z^-1))^K, where K is the order and M is the decimation factor. Every accepted input sample advances all K integrators. After every M accepted samples, the last integrator value passes once through the K comb stages. The result appears on a wide raw output with a one-cycle strobe.

The accumulator width follows the bit-growth rule W = IN_W + K*ceil(log2 M). Intermediate integrator values wrap modulo 2^W, and the final difference is still exact. The raw result carries a DC gain of M^K. A pipelined divider, selected by a parameter, divides each raw result by M^K, and M does not have to be a power of two. The divider accepts a new dividend every cycle, so it never stalls the stream. A typical use is the coarse first stage in front of a compensating FIR.

Top module: `cic_decim`

## Requirements
- R1: While `rst` is high, and on the first edge after it, both valid strobes are low and `raw_data` reads zero. Reset clears all integrators, comb delays and the sample phase counter.
- R2: A cycle with `in_valid` low changes no state and produces no output.
- R3: Exactly one raw result is produced for every M accepted samples. After reset, the first result follows the M-th accepted sample. Accepted samples are counted across idle gaps.
- R4: `raw_data` equals the comb cascade applied to the integrator cascade. Stage k of the integrator adds the new value of stage k-1 in the same sample. Each comb outputs its input minus its stored previous input. All arithmetic uses W = IN_W + K*ceil(log2 M) bits.
- R5: Integrator sums wrap as two's complement modulo 2^W, with no saturation. Full-scale inputs of 0x7FFF and 0x8000 still give exact results.
- R6: `raw_valid` is a single-cycle strobe. It is high in the cycle right after the edge that accepts the M-th sample.
- R7: `norm_data` equals the signed raw result divided by M^K, truncated toward zero and sign-extended to W bits. This holds for non-power-of-two M (27 for M=3, 15625 for M=25).
- R8: `norm_valid` pulses W+2 cycles after the matching `raw_valid`. A new raw result may enter the divider every cycle.
- R9: Once a constant input x has run for at least K*(M-1)+1 samples, each normalised output equals x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample accepted on this edge |
| in_data | input | IN_W | Signed input sample |
| raw_valid | output | 1 | One-cycle strobe for raw_data |
| raw_data | output | W | Signed comb output, DC gain M^K |
| norm_valid | output | 1 | One-cycle strobe for norm_data |
| norm_data | output | W | Signed raw result divided by M^K |

## Verification
Take the edge that accepts the M-th sample of a group as cycle c. The raw result is due in cycle c+1, and the normalised result is due in cycle c+1+W+2. For W=31, that is 33 cycles after the raw result. The driver computes both due cycles when it pushes an expected item. The monitor samples at the falling edge and compares both the value and the cycle against the queue head. An early, late or missing strobe is therefore reported as a timing failure, not as a data mismatch. Three instances with K=3 and M of 3, 16 and 25 run side by side. They receive gapped random data, long full-scale constant runs that force wrap, alternating extremes and a reset in the middle of a stream.

// File: rtl/cic_pkg.sv
package cic_pkg;

  // Accumulator width needed for exact comb output.
  function automatic int acc_width(int in_w, int order, int decim);
    return in_w + order * $clog2(decim);
  endfunction

  // DC gain M^K of the filter.
  function automatic longint dc_gain(int decim, int order);
    longint g;
    g = 1;
    for (int i = 0; i < order; i++) g = g * decim;
    return g;
  endfunction

  // Sign-extend an input sample to accumulator width (no clipping).
  function automatic logic [63:0] sext64(logic [63:0] v, int w);
    logic [63:0] r;
    r = v;
    for (int i = 0; i < 64; i++)
      if (i >= w) r[i] = v[w-1];
    return r;
  endfunction

endpackage

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
  parameter int ORDER = 3,
  parameter int ACC_W = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [ACC_W-1:0] ext_in,
  output logic [ACC_W-1:0] chain_out
);
  logic [ORDER:0][ACC_W-1:0] sums;

  assign sums[0] = ext_in;

  for (genvar k = 0; k < ORDER; k++) begin : stage
    logic [ACC_W-1:0] acc_q;
    // each stage adds the freshly updated value of the previous one
    assign sums[k+1] = acc_q + sums[k];
    always_ff @(posedge clk) begin
      if (rst)       acc_q <= '0;
      else if (step) acc_q <= sums[k+1];
    end
  end

  assign chain_out = sums[ORDER];
endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int ORDER = 3,
  parameter int ACC_W = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [ACC_W-1:0] din,
  output logic             dout_valid,
  output logic [ACC_W-1:0] dout
);
  logic [ORDER:0][ACC_W-1:0] diffs;

  assign diffs[0] = din;

  for (genvar k = 0; k < ORDER; k++) begin : stage
    logic [ACC_W-1:0] dly_q;
    assign diffs[k+1] = diffs[k] - dly_q;
    always_ff @(posedge clk) begin
      if (rst)       dly_q <= '0;
      else if (fire) dly_q <= diffs[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_valid <= 1'b0;
      dout       <= '0;
    end else begin
      dout_valid <= fire;
      if (fire) dout <= diffs[ORDER];
    end
  end
endmodule

// File: rtl/cic_norm_div.sv
module cic_norm_div #(
  parameter int     ACC_W   = 31,
  parameter longint DIVISOR = 15625,
  parameter int     DIV_W   = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [ACC_W-1:0] dividend,
  output logic             out_valid,
  output logic [ACC_W-1:0] quotient
);
  localparam logic [DIV_W:0] DV = (DIV_W+1)'(DIVISOR);

  // stage 0: split sign and magnitude
  logic             vld0_q, sgn0_q;
  logic [ACC_W-1:0] mag0_q;

  always_ff @(posedge clk) begin
    if (rst) vld0_q <= 1'b0;
    else     vld0_q <= in_valid;
    sgn0_q <= dividend[ACC_W-1];
    mag0_q <= dividend[ACC_W-1] ? (~dividend + 1'b1) : dividend;
  end

  // one restoring quotient bit per stage
  for (genvar k = 0; k < ACC_W; k++) begin : stg
    logic [DIV_W-1:0] rem_in;
    logic [ACC_W-1:0] num_in;
    logic             sgn_in, vld_in;
    logic [DIV_W:0]   trial;
    logic             take;
    logic [ACC_W-1:0] num_q;
    logic             sgn_q, vld_q;

    if (k == 0) begin : head
      assign rem_in = '0;
      assign num_in = mag0_q;
      assign sgn_in = sgn0_q;
      assign vld_in = vld0_q;
    end else begin : link
      assign rem_in = stg[k-1].keep.rem_q;
      assign num_in = stg[k-1].num_q;
      assign sgn_in = stg[k-1].sgn_q;
      assign vld_in = stg[k-1].vld_q;
    end

    assign trial = {rem_in, num_in[ACC_W-1]};
    assign take  = (trial >= DV);

    always_ff @(posedge clk) begin
      if (rst) vld_q <= 1'b0;
      else     vld_q <= vld_in;
      num_q <= {num_in[ACC_W-2:0], take};
      sgn_q <= sgn_in;
    end

    if (k < ACC_W - 1) begin : keep
      logic [DIV_W-1:0] rem_q;
      always_ff @(posedge clk)
        rem_q <= take ? DIV_W'(trial - DV) : trial[DIV_W-1:0];
    end
  end

  // final stage: restore sign
  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= stg[ACC_W-1].vld_q;
    quotient <= stg[ACC_W-1].sgn_q ? (~stg[ACC_W-1].num_q + 1'b1)
                                   : stg[ACC_W-1].num_q;
  end
endmodule

// File: rtl/cic_decim.sv
module cic_decim
  import cic_pkg::*;
#(
  parameter  int IN_W    = 16,
  parameter  int ORDER   = 3,
  parameter  int DECIM   = 25,
  parameter  bit NORM_EN = 1'b1,
  localparam int ACC_W   = acc_width(IN_W, ORDER, DECIM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             raw_valid,
  output logic [ACC_W-1:0] raw_data,
  output logic             norm_valid,
  output logic [ACC_W-1:0] norm_data
);
  localparam int     CNT_W = $clog2(DECIM);
  localparam longint GAIN  = dc_gain(DECIM, ORDER);
  localparam int     DIV_W = $clog2(GAIN + 1);

  logic [CNT_W-1:0] phase_q;
  logic             dump;
  logic [ACC_W-1:0] ext_in, integ_out;

  assign ext_in = {{(ACC_W-IN_W){in_data[IN_W-1]}}, in_data};
  assign dump   = in_valid && (phase_q == CNT_W'(DECIM - 1));

  always_ff @(posedge clk) begin
    if (rst)           phase_q <= '0;
    else if (in_valid) phase_q <= dump ? '0 : phase_q + 1'b1;
  end

  cic_integ_chain #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
    .clk(clk), .rst(rst), .step(in_valid), .ext_in(ext_in),
    .chain_out(integ_out)
  );

  cic_comb_chain #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
    .clk(clk), .rst(rst), .fire(dump), .din(integ_out),
    .dout_valid(raw_valid), .dout(raw_data)
  );

  if (NORM_EN) begin : g_norm
    cic_norm_div #(.ACC_W(ACC_W), .DIVISOR(GAIN), .DIV_W(DIV_W)) u_div (
      .clk(clk), .rst(rst), .in_valid(raw_valid), .dividend(raw_data),
      .out_valid(norm_valid), .quotient(norm_data)
    );
  end else begin : g_raw_only
    assign norm_valid = 1'b0;
    assign norm_data  = '0;
  end
endmodule

// File: rtl/cic_decim_chk.sv
module cic_decim_chk #(
  parameter int DECIM   = 25,
  parameter int LAT     = 33,
  parameter bit NORM_EN = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic dump,
  input logic raw_valid,
  input logic norm_valid
);
  localparam int CW = $clog2(DECIM);
  localparam int LW = $clog2(LAT + 1);

  logic [CW-1:0] seen;
  logic [7:0]    inflight;
  logic [LW-1:0] since_first;
  logic          started;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen        <= '0;
      inflight    <= '0;
      since_first <= '0;
      started     <= 1'b0;
    end else begin
      if (in_valid) seen <= (seen == CW'(DECIM - 1)) ? '0 : seen + 1'b1;
      inflight <= inflight + 8'(raw_valid && NORM_EN) - 8'(norm_valid);
      if (raw_valid) started <= 1'b1;
      if ((started || raw_valid) && since_first != LW'(LAT)) since_first <= since_first + 1'b1;
    end
  end

  // R1: outputs quiet straight after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!raw_valid && !norm_valid));

  // R3: comb fires on the M-th accepted sample, never elsewhere
  a_r3_dump_on_mth: assert property (@(posedge clk) disable iff (rst)
    (in_valid && seen == CW'(DECIM - 1)) |-> dump);
  a_r3_dump_only_mth: assert property (@(posedge clk) disable iff (rst)
    dump |-> (in_valid && seen == CW'(DECIM - 1)));

  // R6: raw strobe is exactly one cycle after the comb fires
  a_r6_raw_follows_dump: assert property (@(posedge clk) disable iff (rst)
    dump |=> raw_valid);
  a_r6_raw_needs_dump: assert property (@(posedge clk) disable iff (rst)
    raw_valid |-> $past(dump));

  // R8: every normalised result has a raw source at least LAT cycles old
  a_r8_norm_has_source: assert property (@(posedge clk) disable iff (rst)
    norm_valid |-> (inflight != 8'd0));
  a_r8_norm_not_early: assert property (@(posedge clk) disable iff (rst)
    norm_valid |-> (since_first == LW'(LAT)));
endmodule

bind cic_decim cic_decim_chk #(
  .DECIM(DECIM), .LAT(ACC_W + 2), .NORM_EN(NORM_EN)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .dump(dump),
  .raw_valid(raw_valid), .norm_valid(norm_valid)
);

// File: tb/cic_decim_test.sv
module cic_lane #(
  parameter int M = 3
) (
  input  logic clk,
  output logic done,
  output int   errs_o,
  output int   checks_o
);
  localparam int IN_W = 16;
  localparam int K    = 3;
  localparam int W    = IN_W + K * $clog2(M);
  localparam int LAT  = W + 2;

  function automatic longint gain_of();
    longint g = 1;
    for (int i = 0; i < K; i++) g *= M;
    return g;
  endfunction
  localparam longint G = gain_of();

  logic            rst, in_valid;
  logic [IN_W-1:0] in_data;
  logic            raw_valid, norm_valid;
  logic [W-1:0]    raw_data, norm_data;

  cic_decim #(.IN_W(IN_W), .ORDER(K), .DECIM(M), .NORM_EN(1'b1)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .raw_valid(raw_valid), .raw_data(raw_data),
    .norm_valid(norm_valid), .norm_data(norm_data)
  );

  typedef struct { logic [W-1:0] v; longint at; } item_t;

  int         errs = 0, checks = 0, raw_seen = 0;
  longint     cyc = 0;
  logic [W-1:0] mi [K];
  logic [W-1:0] md [K];
  int         mcnt;
  bit         wrapped = 0;
  item_t      rq[$], nq[$];
  logic [W-1:0] last_norm = '0;

  assign errs_o   = errs;
  assign checks_o = checks;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s M=%0d %s: actual=%0d expected=%0d", req, M, what, act, exp);
    end
  endtask

  function automatic longint sv(logic [W-1:0] x);
    return longint'($signed(x));
  endfunction

  // reference: accumulate in W bits, comb every M-th sample
  task automatic model_sample(logic [IN_W-1:0] x);
    logic [W-1:0] v, tmp;
    longint wide;
    v = W'(longint'($signed(x)));
    for (int k = 0; k < K; k++) begin
      wide  = sv(mi[k]) + sv(v);
      mi[k] = mi[k] + v;
      if (wide != sv(mi[k])) wrapped = 1;
      v = mi[k];
    end
    mcnt++;
    if (mcnt == M) begin
      mcnt = 0;
      for (int k = 0; k < K; k++) begin
        tmp   = v;
        v     = v - md[k];
        md[k] = tmp;
      end
      rq.push_back('{v, cyc + 1});
      nq.push_back('{W'(sv(v) / G), cyc + 1 + LAT});
    end
  endtask

  task automatic send(logic [IN_W-1:0] x, bit v);
    @(posedge clk);
    #1;
    in_valid = v;
    in_data  = x;
    if (v) model_sample(x);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) send('0, 1'b0);
  endtask

  task automatic do_reset();
    @(posedge clk);
    #1;
    rst = 1'b1;
    in_valid = 1'b0;
    for (int k = 0; k < K; k++) begin mi[k] = '0; md[k] = '0; end
    mcnt = 0;
    rq.delete();
    nq.delete();
    repeat (3) @(posedge clk);
    #1;
    check(!raw_valid && !norm_valid, "R1", "strobes during reset",
          {raw_valid, norm_valid}, 0);
    check(raw_data == '0, "R1", "raw_data during reset", sv(raw_data), 0);
    rst = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (raw_valid) begin
        item_t e;
        raw_seen++;
        if (rq.size() == 0) check(1'b0, "R3", "unexpected raw strobe", cyc, -1);
        else begin
          e = rq.pop_front();
          check(raw_data == e.v, "R4", "raw value", sv(raw_data), sv(e.v));
          check(cyc == e.at, "R6", "raw cycle", cyc, e.at);
        end
      end
      if (norm_valid) begin
        item_t e;
        last_norm = norm_data;
        if (nq.size() == 0) check(1'b0, "R8", "unexpected norm strobe", cyc, -1);
        else begin
          e = nq.pop_front();
          check(norm_data == e.v, "R7", "normalised value", sv(norm_data), sv(e.v));
          check(cyc == e.at, "R8", "normalised cycle", cyc, e.at);
        end
      end
    end
  end

  initial begin
    int r;
    done = 1'b0;
    rst = 1'b1;
    in_valid = 1'b0;
    in_data = '0;
    do_reset();

    // R3: M-1 samples with idle gap give nothing; the M-th gives a result
    for (int i = 0; i < M - 1; i++) send(16'(i * 97 + 5), 1'b1);
    r = raw_seen;
    idle(2 * M + 4);
    check(raw_seen == r, "R2", "no output while idle", raw_seen, r);
    send(16'h1234, 1'b1);
    idle(LAT + 3);
    check(raw_seen == r + 1, "R3", "first result after M-th sample", raw_seen, r + 1);

    // gapped random traffic (R2, R4, R7)
    for (int i = 0; i < 40 * M; i++) send(16'($urandom), ($urandom % 4) != 0);

    // R9 + R5: positive full-scale DC
    for (int i = 0; i < 40 * M; i++) send(16'h7FFF, 1'b1);
    idle(LAT + 3);
    check(sv(last_norm) == 32767, "R9", "positive DC normalised", sv(last_norm), 32767);

    // R9 + R5: negative full-scale DC
    for (int i = 0; i < 40 * M; i++) send(16'h8000, 1'b1);
    idle(LAT + 3);
    check(sv(last_norm) == -32768, "R9", "negative DC normalised", sv(last_norm), -32768);

    // alternating extremes
    for (int i = 0; i < 20 * M; i++) send((i % 2) ? 16'h8000 : 16'h7FFF, 1'b1);

    // reset in mid-stream: phase restarts
    for (int i = 0; i < M / 2 + 1; i++) send(16'h4000, 1'b1);
    do_reset();
    for (int i = 0; i < M - 1; i++) send(16'h0100, 1'b1);
    r = raw_seen;
    idle(M + 2);
    check(raw_seen == r, "R3", "phase cleared by reset", raw_seen, r);
    send(16'h0100, 1'b1);
    for (int i = 0; i < 10 * M; i++) send(16'($urandom), 1'b1);

    idle(LAT + 5);
    check(rq.size() == 0, "R3", "raw results outstanding", rq.size(), 0);
    check(nq.size() == 0, "R8", "normalised results outstanding", nq.size(), 0);
    check(wrapped, "R5", "integrator wrap exercised", wrapped, 1);
    done = 1'b1;
  end
endmodule

module cic_decim_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic d3, d16, d25;
  int   e3, e16, e25, c3, c16, c25;
  bit   wd = 1'b0;

  cic_lane #(.M(3))  lane_m3  (.clk(clk), .done(d3),  .errs_o(e3),  .checks_o(c3));
  cic_lane #(.M(16)) lane_m16 (.clk(clk), .done(d16), .errs_o(e16), .checks_o(c16));
  cic_lane #(.M(25)) lane_m25 (.clk(clk), .done(d25), .errs_o(e25), .checks_o(c25));

  initial begin
    repeat (150000) @(posedge clk);
    wd = 1'b1;
  end

  initial begin
    int errs, checks;
    wait ((d3 && d16 && d25) || wd);
    @(negedge clk);
    errs   = e3 + e16 + e25;
    checks = c3 + c16 + c25;
    if (wd && !(d3 && d16 && d25)) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=all lanes done");
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule